// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block sits between a 16-bit host register bus and an 8-bit NAND flash device. The host picks the NAND cycle type by writing one mode byte. That byte directly drives chip enable, the command latch (CLE), the address latch (ALE), the write-protect release, two power-control outputs and two control lines for an external ECC engine. Each access to the data register becomes one or two NAND byte cycles. The host bus stalls until all of those cycles are finished.

The NAND ready/busy line passes through a synchronizer. Its synchronized level is readable as a busy bit. Its busy-to-ready transition is latched as an event flag, which raises an interrupt when the mask allows it. Every byte moved in a pure data phase (CLE and ALE both low) is copied onto a one-cycle snoop port for a separate ECC block. Strobe width and recovery time are fixed by parameters.

Top module: `nfb_bridge`

## Requirements
- R1: After reset the mode byte is 0x00: nf_ce_n=1, nf_cle=0, nf_ale=0, nf_we_n=1, nf_re_n=1, nf_wp_n=0, pwr_ctl=0, irq=0, ecc_byte_vld=0, and a mode read returns 0x0000.
- R2: The mode byte drives the pins as follows. Bit 0 is CLE, bit 1 is ALE, bits 3:2 are pwr_ctl, bit 4 asserts chip enable (nf_ce_n = !bit4), bits 6:5 are ecc_ctl, and bit 7 drives nf_wp_n. 0x94 selects data cycles, 0x95 command cycles, 0x96 address cycles, 0x00 standby, 0x0C power on and 0x08 power off.
- R3: The host registers sit at these addresses: data 0, mode 1, status 2, event flag 3, interrupt mask 4. A read of mode, flag or mask returns the stored byte in hb_rdata[7:0] with the upper byte zero. Register accesses complete with hb_ready in the same cycle.
- R4: A 16-bit write (hb_wide=1) to the data register issues two NAND write cycles: first hb_wdata[7:0], then hb_wdata[15:8]. nf_io_out stays stable while nf_we_n is low, and each byte carries the current CLE/ALE levels.
- R5: An 8-bit write (hb_wide=0) to the data register issues exactly one NAND write cycle carrying hb_wdata[7:0], for example the reset command 0xFF in command mode.
- R6: Each NAND strobe (nf_we_n or nf_re_n) stays low for exactly PULSE_CYC clocks and is followed by GAP_CYC clocks high. The two strobes are never low together.
- R7: A 16-bit read returns {second byte, first byte}. An 8-bit read returns {8'h00, byte}. The byte is sampled from nf_io_in on the last low clock of nf_re_n.
- R8: A data access with n bytes raises hb_ready after n*(PULSE_CYC+GAP_CYC)+1 clock edges, counted from the first edge that sees hb_sel.
- R9: Status bit 7 reads 1 while the synchronized nf_rb is low (busy). The other status bits read 0. A change on nf_rb reaches the status bit after SYNC_STAGES edges.
- R10: A rising (busy-to-ready) transition of nf_rb sets event flag bit 0. The flag is set at edge SYNC_STAGES+1 after the input change. A falling transition does not set it. Writing the flag register with bit 0 set (for example 0x0F) clears it. Writing 0x00 leaves it set.
- R11: irq = flag AND mask bit 0 AND mask bit 7. A mask of 0x81 enables the interrupt and 0x00 disables it, without changing the flag.
- R12: Every byte moved while CLE=0 and ALE=0 appears on ecc_byte with ecc_byte_vld high for one cycle, in transfer order. Command and address bytes never appear there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_sel | input | 1 | Host access request, held until hb_ready |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| hb_addr | input | 3 | Register select |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, valid with hb_ready |
| hb_ready | output | 1 | Access completes at this clock |
| nf_ce_n | output | 1 | NAND chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write-protect release |
| nf_io_out | output | 8 | Byte driven to the NAND |
| nf_io_oe | output | 1 | Output enable for nf_io_out |
| nf_io_in | input | 8 | Byte from the NAND |
| nf_rb | input | 1 | NAND ready/busy, 1 = ready |
| pwr_ctl | output | 2 | Media power control bits |
| ecc_ctl | output | 2 | Control lines for the ECC block |
| ecc_byte | output | 8 | Snooped data byte |
| ecc_byte_vld | output | 1 | Snooped byte valid |
| irq | output | 1 | Ready interrupt |

## Verification
Register accesses must show hb_ready before any clock edge. Data accesses must show it exactly n*(PULSE_CYC+GAP_CYC)+1 edges after the request. The bus task counts the edges it waits and compares that count with the same sum. NAND-side bytes and snooped ECC bytes are pushed into scoreboard queues when an access is issued. Monitors pop those queues on each rising nf_we_n and on each valid snoop cycle, so every byte is checked in the cycle it is produced. Ready/busy effects are sampled on both sides of their due edge: one edge before the status bit turns (edge SYNC_STAGES), and at the edges just before and at the one where the flag is due (edge SYNC_STAGES+1).

// File: rtl/nfb_pkg.sv
package nfb_pkg;

  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_MODE  = 3'd1,
    REG_STAT  = 3'd2,
    REG_FLAG  = 3'd3,
    REG_MASK  = 3'd4
  } reg_sel_e;

  localparam int MB_CLE   = 0;
  localparam int MB_ALE   = 1;
  localparam int MB_PWR   = 2;
  localparam int MB_CE    = 4;
  localparam int MB_ECC   = 5;
  localparam int MB_WREN  = 7;

  localparam int STAT_BUSY = 7;
  localparam int MASK_RDY  = 0;
  localparam int MASK_GATE = 7;

  // pure data phase: neither latch enable set
  function automatic logic is_data_phase(input logic [7:0] mode);
    return !mode[MB_CLE] && !mode[MB_ALE];
  endfunction

  function automatic logic irq_level(input logic flag, input logic [7:0] mask);
    return flag && mask[MASK_RDY] && mask[MASK_GATE];
  endfunction

  function automatic logic [15:0] status_word(input logic rb_level);
    logic [15:0] w;
    w = '0;
    w[STAT_BUSY] = !rb_level;
    return w;
  endfunction

endpackage

// File: rtl/nfb_byte_engine.sv
module nfb_byte_engine #(
  parameter int PULSE_CYC = 3,
  parameter int GAP_CYC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr_req,
  input  logic        wide_req,
  input  logic        data_phase,
  input  logic [15:0] wdata,
  input  logic [7:0]  io_in,
  output logic        idle,
  output logic        done,
  output logic [15:0] rdata,
  output logic [7:0]  io_out,
  output logic        io_oe,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  snoop_byte,
  output logic        snoop_vld,
  output logic        byte_end
);
  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int LW   = $clog2(PULSE_CYC + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_GAP, ST_DONE} eng_state_e;

  eng_state_e  state;
  logic [CW-1:0] cnt;
  logic        hi_byte, two, is_wr;
  logic [15:0] wbuf, rbuf;
  logic [7:0]  io_q;
  logic        pulse_last, gap_last;

  assign pulse_last = (state == ST_STROBE) && (cnt == CW'(PULSE_CYC - 1));
  assign gap_last   = (state == ST_GAP) && (cnt == CW'(GAP_CYC - 1));
  assign byte_end   = pulse_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hi_byte <= 1'b0;
      two     <= 1'b0;
      is_wr   <= 1'b0;
      wbuf    <= '0;
      rbuf    <= '0;
      io_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          is_wr   <= wr_req;
          two     <= wide_req;
          wbuf    <= wdata;
          io_q    <= wdata[7:0];
          rbuf    <= '0;
          hi_byte <= 1'b0;
          cnt     <= '0;
          state   <= ST_STROBE;
        end
        ST_STROBE: begin
          if (pulse_last) begin
            cnt   <= '0;
            state <= ST_GAP;
            if (!is_wr) begin
              if (hi_byte) rbuf[15:8] <= io_in;
              else         rbuf[7:0]  <= io_in;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            cnt <= '0;
            if (two && !hi_byte) begin
              hi_byte <= 1'b1;
              io_q    <= wbuf[15:8];
              state   <= ST_STROBE;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // snoop copy of data-phase bytes, one cycle after the byte completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoop_vld  <= 1'b0;
      snoop_byte <= '0;
    end else begin
      snoop_vld <= pulse_last && data_phase;
      if (pulse_last) snoop_byte <= is_wr ? io_q : io_in;
    end
  end

  assign idle   = (state == ST_IDLE);
  assign done   = (state == ST_DONE);
  assign rdata  = rbuf;
  assign io_out = io_q;
  assign io_oe  = is_wr && ((state == ST_STROBE) || (state == ST_GAP));
  assign we_n   = !((state == ST_STROBE) && is_wr);
  assign re_n   = !((state == ST_STROBE) && !is_wr);

  // strobe width watcher for the assertion below
  logic          strobe_lo;
  logic [LW-1:0] low_run;
  assign strobe_lo = !we_n || !re_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (strobe_lo) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R6
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_lo && $past(strobe_lo)) |-> (low_run == LW'(PULSE_CYC))); // R6
  AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(io_out)); // R4
  AST_SNOOP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_vld |=> !snoop_vld); // R12

endmodule

// File: rtl/nfb_ready_irq.sv
module nfb_ready_irq
  import nfb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rb_async,
  input  logic       clr_wr,
  input  logic       clr_bit,
  input  logic       mask_wr,
  input  logic [7:0] mask_data,
  output logic       rb_sync,
  output logic       ready_edge,
  output logic       flag,
  output logic [7:0] mask,
  output logic       irq
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   rb_prev;

  // reset to "ready" so a ready line at reset is not taken as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain   <= '1;
      rb_prev <= 1'b1;
    end else begin
      chain   <= {chain[SYNC_STAGES-2:0], rb_async};
      rb_prev <= chain[SYNC_STAGES-1];
    end
  end

  assign rb_sync    = chain[SYNC_STAGES-1];
  assign ready_edge = rb_sync && !rb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      mask <= '0;
    end else begin
      if (ready_edge)              flag <= 1'b1;
      else if (clr_wr && clr_bit)  flag <= 1'b0;
      if (mask_wr) mask <= mask_data;
    end
  end

  assign irq = irq_level(flag, mask);

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ready_edge |=> flag); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bit && !ready_edge) |=> !flag); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(clr_wr && clr_bit)) |=> flag); // R10

endmodule

// File: rtl/nfb_host_regs.sv
module nfb_host_regs
  import nfb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [7:0]  wbyte,
  input  logic        eng_idle,
  input  logic        eng_done,
  input  logic [15:0] eng_rdata,
  input  logic        rb_sync,
  input  logic        flag,
  input  logic [7:0]  mask,
  output logic [7:0]  mode,
  output logic        eng_start,
  output logic        ready,
  output logic [15:0] rdata,
  output logic        clr_wr,
  output logic        mask_wr
);
  logic hit_data, mode_wr;

  assign hit_data  = sel && (addr == REG_DATA);
  assign eng_start = hit_data && eng_idle;
  assign ready     = (sel && !hit_data) || (hit_data && eng_done);
  assign mode_wr   = sel && wr && (addr == REG_MODE);
  assign clr_wr    = sel && wr && (addr == REG_FLAG);
  assign mask_wr   = sel && wr && (addr == REG_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= 8'h00;
    else if (mode_wr) mode <= wbyte;
  end

  always_comb begin
    case (addr)
      REG_DATA: rdata = eng_rdata;
      REG_MODE: rdata = {8'h00, mode};
      REG_STAT: rdata = status_word(rb_sync);
      REG_FLAG: rdata = {15'd0, flag};
      REG_MASK: rdata = {8'h00, mask};
      default:  rdata = 16'h0000;
    endcase
  end

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode)); // R3
  AST_DATA_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !ready); // R8

endmodule

// File: rtl/nfb_bridge.sv
module nfb_bridge
  import nfb_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int GAP_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hb_sel,
  input  logic        hb_wr,
  input  logic        hb_wide,
  input  logic [2:0]  hb_addr,
  input  logic [15:0] hb_wdata,
  output logic [15:0] hb_rdata,
  output logic        hb_ready,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic        nf_wp_n,
  output logic [7:0]  nf_io_out,
  output logic        nf_io_oe,
  input  logic [7:0]  nf_io_in,
  input  logic        nf_rb,
  output logic [1:0]  pwr_ctl,
  output logic [1:0]  ecc_ctl,
  output logic [7:0]  ecc_byte,
  output logic        ecc_byte_vld,
  output logic        irq
);
  logic [7:0]  mode, mask;
  logic        eng_start, eng_idle, eng_done, byte_end;
  logic [15:0] eng_rdata;
  logic        rb_sync, ready_edge, flag, clr_wr, mask_wr;

  nfb_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(hb_sel), .wr(hb_wr), .addr(hb_addr),
    .wbyte(hb_wdata[7:0]), .eng_idle(eng_idle), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .rb_sync(rb_sync), .flag(flag), .mask(mask),
    .mode(mode), .eng_start(eng_start), .ready(hb_ready), .rdata(hb_rdata),
    .clr_wr(clr_wr), .mask_wr(mask_wr)
  );

  nfb_byte_engine #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .wr_req(hb_wr),
    .wide_req(hb_wide), .data_phase(is_data_phase(mode)), .wdata(hb_wdata),
    .io_in(nf_io_in), .idle(eng_idle), .done(eng_done), .rdata(eng_rdata),
    .io_out(nf_io_out), .io_oe(nf_io_oe), .we_n(nf_we_n), .re_n(nf_re_n),
    .snoop_byte(ecc_byte), .snoop_vld(ecc_byte_vld), .byte_end(byte_end)
  );

  nfb_ready_irq #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rb_async(nf_rb), .clr_wr(clr_wr),
    .clr_bit(hb_wdata[0]), .mask_wr(mask_wr), .mask_data(hb_wdata[7:0]),
    .rb_sync(rb_sync), .ready_edge(ready_edge), .flag(flag), .mask(mask),
    .irq(irq)
  );

  assign nf_cle  = mode[MB_CLE];
  assign nf_ale  = mode[MB_ALE];
  assign nf_ce_n = !mode[MB_CE];
  assign nf_wp_n = mode[MB_WREN];
  assign pwr_ctl = mode[MB_PWR +: 2];
  assign ecc_ctl = mode[MB_ECC +: 2];

  AST_SNOOP_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_byte_vld |-> $past(byte_end)); // R12
  AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ready_edge) || $past(mask_wr))); // R11

endmodule

// File: tb/nfb_bridge_test.sv
`timescale 1ns/1ps
module nfb_bridge_test;
  localparam int P = 3;
  localparam int G = 2;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_sel = 1'b0, hb_wr = 1'b0, hb_wide = 1'b0;
  logic [2:0]  hb_addr = 3'd0;
  logic [15:0] hb_wdata = 16'h0;
  logic [15:0] hb_rdata;
  logic        hb_ready;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_io_oe;
  logic [7:0]  nf_io_out;
  logic [7:0]  nf_io_in = 8'h00;
  logic        nf_rb = 1'b1;
  logic [1:0]  pwr_ctl, ecc_ctl;
  logic [7:0]  ecc_byte;
  logic        ecc_byte_vld, irq;

  int checks = 0;
  int fails  = 0;
  logic [9:0] exp_nf[$];
  logic [7:0] exp_ecc[$];
  logic [7:0] cur_mode = 8'h00;
  int nand_idx = 0;
  int exp_idx  = 0;
  int we_low = 0, re_low = 0;

  always #2 clk = ~clk;

  nfb_bridge #(.PULSE_CYC(P), .GAP_CYC(G), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_wide(hb_wide),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_ready(hb_ready), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
    .nf_rb(nf_rb), .pwr_ctl(pwr_ctl), .ecc_ctl(ecc_ctl), .ecc_byte(ecc_byte),
    .ecc_byte_vld(ecc_byte_vld), .irq(irq)
  );

  function automatic logic [7:0] nand_pat(input int i);
    return 8'h5A ^ 8'(i * 37);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // NAND model: next read byte appears when RE# falls
  always @(negedge nf_re_n) begin
    nf_io_in <= nand_pat(nand_idx);
    nand_idx++;
  end

  // scoreboard monitor, NAND write side
  always @(posedge nf_we_n) begin
    if (rst_n) begin
      if (exp_nf.size() == 0) chk(1'b0, "R4 unexpected write byte", {22'd0, nf_cle, nf_ale, nf_io_out}, 0);
      else begin
        logic [9:0] e;
        e = exp_nf.pop_front();
        chk({nf_cle, nf_ale, nf_io_out} == e, "R4/R5 nand byte",
            {22'd0, nf_cle, nf_ale, nf_io_out}, {22'd0, e});
      end
    end
  end

  // scoreboard monitor, ECC snoop side; strobe width monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ecc_byte_vld) begin
        if (exp_ecc.size() == 0) chk(1'b0, "R12 unexpected snoop", {24'd0, ecc_byte}, 0);
        else begin
          logic [7:0] e;
          e = exp_ecc.pop_front();
          chk(ecc_byte == e, "R12 snoop byte", {24'd0, ecc_byte}, {24'd0, e});
        end
      end
      if (!nf_we_n && !nf_re_n) chk(1'b0, "R6 both strobes low", 1, 0);
      if (!nf_we_n) we_low++;
      else if (we_low != 0) begin chk(we_low == P, "R6 we width", we_low, P); we_low = 0; end
      if (!nf_re_n) re_low++;
      else if (re_low != 0) begin chk(re_low == P, "R6 re width", re_low, P); re_low = 0; end
    end
  end

  // one host access, started at a falling edge; lat = edges waited
  task automatic bus(input logic wr, input logic wide, input logic [2:0] a,
                     input logic [15:0] d, output logic [15:0] rd, output int lat);
    hb_sel = 1'b1; hb_wr = wr; hb_wide = wide; hb_addr = a; hb_wdata = d;
    lat = 0;
    forever begin
      #1;
      if (hb_ready) break;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    rd = hb_rdata;
    @(posedge clk);
    @(negedge clk);
    hb_sel = 1'b0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] v);
    logic [15:0] rd; int lat;
    bus(1'b1, 1'b0, a, {8'h00, v}, rd, lat);
    chk(lat == 0, "R3 reg write latency", lat, 0);
    if (a == 3'd1) cur_mode = v;
  endtask

  task automatic reg_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] rd; int lat;
    bus(1'b0, 1'b0, a, 16'h0, rd, lat);
    chk(rd == exp && lat == 0, tag, {lat[15:0], rd}, {16'd0, exp});
  endtask

  task automatic nand_wr(input logic wide, input logic [15:0] d);
    logic [15:0] rd; int lat; int n;
    n = wide ? 2 : 1;
    exp_nf.push_back({cur_mode[0], cur_mode[1], d[7:0]});
    if (!cur_mode[0] && !cur_mode[1]) exp_ecc.push_back(d[7:0]);
    if (wide) begin
      exp_nf.push_back({cur_mode[0], cur_mode[1], d[15:8]});
      if (!cur_mode[0] && !cur_mode[1]) exp_ecc.push_back(d[15:8]);
    end
    bus(1'b1, wide, 3'd0, d, rd, lat);
    chk(lat == n * (P + G) + 1, "R8 write latency", lat, n * (P + G) + 1);
  endtask

  task automatic nand_rd(input logic wide);
    logic [15:0] rd, exp; int lat; int n;
    n = wide ? 2 : 1;
    exp = {8'h00, nand_pat(exp_idx)};
    exp_ecc.push_back(nand_pat(exp_idx));
    exp_idx++;
    if (wide) begin
      exp[15:8] = nand_pat(exp_idx);
      exp_ecc.push_back(nand_pat(exp_idx));
      exp_idx++;
    end
    bus(1'b0, wide, 3'd0, 16'h0, rd, lat);
    chk(rd == exp, "R7 read data", {16'd0, rd}, {16'd0, exp});
    chk(lat == n * (P + G) + 1, "R8 read latency", lat, n * (P + G) + 1);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, pwr_ctl, irq, ecc_byte_vld}
        == 10'b1001100000, "R1 reset pins",
        {22'd0, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, pwr_ctl, irq, ecc_byte_vld},
        32'b1001100000);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(3'd1, 16'h0000, "R1 mode after reset");

    // R2 power and mode encodings
    reg_wr(3'd1, 8'h0C);
    chk(pwr_ctl == 2'b11 && nf_ce_n, "R2 power on", {30'd0, pwr_ctl}, 3);
    reg_wr(3'd1, 8'h08);
    chk(pwr_ctl == 2'b10, "R2 power off", {30'd0, pwr_ctl}, 2);
    reg_wr(3'd1, 8'hB4);
    chk(ecc_ctl == 2'b01 && !nf_ce_n && nf_wp_n, "R2 ecc ctl", {30'd0, ecc_ctl}, 1);
    reg_rd(3'd1, 16'h00B4, "R3 mode readback");

    // R5 command byte
    reg_wr(3'd1, 8'h95);
    chk(nf_cle && !nf_ale && !nf_ce_n, "R2 command mode", {31'd0, nf_cle}, 1);
    nand_wr(1'b0, 16'hABFF);
    // R4 address bytes, 16-bit
    reg_wr(3'd1, 8'h96);
    chk(!nf_cle && nf_ale, "R2 address mode", {31'd0, nf_ale}, 1);
    nand_wr(1'b1, 16'h3412);
    // R4 R12 data bytes
    reg_wr(3'd1, 8'h94);
    nand_wr(1'b1, 16'hBEEF);
    nand_wr(1'b0, 16'h0077);
    // R7 reads
    nand_rd(1'b1);
    nand_rd(1'b0);
    nand_rd(1'b1);

    // R9 busy status through the synchronizer
    reg_wr(3'd4, 8'h81);
    reg_rd(3'd4, 16'h0081, "R11 mask readback");
    nf_rb = 1'b0;
    edges(1);
    reg_rd(3'd2, 16'h0000, "R9 busy not yet visible");
    reg_rd(3'd2, 16'h0080, "R9 busy visible");
    reg_rd(3'd3, 16'h0000, "R10 falling edge ignored");

    // R10 R11 ready edge
    nf_rb = 1'b1;
    edges(2);
    chk(!irq, "R10 irq before due edge", {31'd0, irq}, 0);
    edges(1);
    chk(irq, "R10 irq at due edge", {31'd0, irq}, 1);
    reg_rd(3'd3, 16'h0001, "R10 flag set");
    reg_rd(3'd2, 16'h0000, "R9 ready status");
    reg_wr(3'd3, 8'h00);
    reg_rd(3'd3, 16'h0001, "R10 zero write keeps flag");
    reg_wr(3'd4, 8'h00);
    chk(!irq, "R11 masked irq", {31'd0, irq}, 0);
    reg_rd(3'd3, 16'h0001, "R11 mask keeps flag");
    reg_wr(3'd4, 8'h81);
    chk(irq, "R11 unmasked irq", {31'd0, irq}, 1);
    reg_wr(3'd3, 8'h0F);
    chk(!irq, "R10 clear drops irq", {31'd0, irq}, 0);
    reg_rd(3'd3, 16'h0000, "R10 flag cleared");

    // standby
    reg_wr(3'd1, 8'h00);
    chk(nf_ce_n && !nf_cle && !nf_ale, "R2 standby", {31'd0, nf_ce_n}, 1);

    edges(4);
    chk(exp_nf.size() == 0, "R4 nand queue drained", exp_nf.size(), 0);
    chk(exp_ecc.size() == 0, "R12 snoop queue drained", exp_ecc.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule